// File: doc/BRIEF.md
# Write Data Pattern Generator

This block drives the data channel of an AXI write port. An upstream command queue hands it one burst at a time: a start address, a beat count (the AXI length field) and a beat size. It sends that burst as `len+1` beats on the W channel, marks the final beat with `wlast`, and then accepts the next command. Write strobes are always fully enabled.

The content of each beat comes from one of six fill modes, picked per burst:
- a seeded pseudo-random sequence,
- a constant value,
- a fixed source identifier,
- the beat's own byte address,
- a single one bit walking through zeros,
- a single zero bit walking through ones.

A per-burst gap setting places idle clocks between consecutive beats, so the same generator can produce either dense traffic or throttled traffic for memory tests.

The fill mode, the value and the gap are sampled together with the command. The pseudo-random state and the walking-bit position belong to the generator, not to a burst. They carry on from one burst to the next.

Top module: `wpat_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the block returns to idle. After that edge, `cmd_ready` is 1 and `wvalid` is 0.
- R2: A command accepted at an edge (`cmd_valid && cmd_ready`) raises `wvalid` after that edge.
  - The burst carries exactly `cmd_len+1` beats, and `wlast` is 1 only on beat number `cmd_len`.
  - `cmd_ready` stays 0 from the acceptance until the last beat is accepted. After that edge, `wvalid` is 0 and `cmd_ready` is 1.
- R3: Fill code 0 (constant): every beat carries `cfg_value` as sampled when the command was accepted.
- R4: Fill code 1 (random): a 32-bit right-shifting Galois LFSR produces the beat data.
  - The next state is `(s>>1) ^ (s[0] ? 32'hA3000000 : 0)`.
  - The LFSR is loaded from `cfg_value[31:0]` at every reset edge. A zero seed is replaced by `32'h00000001`.
  - Beat data is the current state repeated across the 64-bit data word.
  - The state steps once on every accepted beat, whatever the fill mode.
- R5: Fill code 2 (source): every beat carries the `SRC_ID` parameter value, zero-extended.
- R6: Fill code 3 (address): beat k carries `cmd_addr + (k << cmd_size)`, taken modulo 2^ADDR_W and zero-extended.
- R7: Fill code 4 (walking one): beat data is `1 << p`. The position p is 0 after reset and advances by one on every accepted beat, whatever the fill mode. It wraps from 63 to 0 and carries across bursts.
- R8: Fill code 5 (walking zero): beat data is `~(1 << p)`, with the same position p as in R7.
- R9: Between two beats of one burst, `wvalid` is 0 for exactly `cfg_gap` cycles, with `cfg_gap` sampled at command acceptance. When the gap is 0, beats are sent back to back.
- R10: While `wvalid` is 1 and `wready` is 0, the block keeps `wvalid`, `wdata` and `wlast` unchanged in the next cycle.
- R11: `wstrb` is all ones on every beat.
- R12: Fill codes 6 and 7 behave as constant mode (R3).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; also loads the LFSR seed |
| cmd_valid | input | 1 | Burst command offered |
| cmd_ready | output | 1 | Generator idle, command can be taken |
| cmd_addr | input | ADDR_W | Burst start byte address |
| cmd_len | input | LEN_W | Beats in burst minus one |
| cmd_size | input | SIZE_W | log2 of bytes per beat |
| cfg_mode | input | 3 | Fill mode code |
| cfg_value | input | DATA_W | Constant value / LFSR seed |
| cfg_gap | input | GAP_W | Idle clocks between beats |
| wvalid | output | 1 | Write data beat valid |
| wready | input | 1 | Write data beat accepted |
| wdata | output | DATA_W | Beat data |
| wstrb | output | DATA_W/8 | Byte strobes |
| wlast | output | 1 | Final beat of burst |

## Verification
Each result has its own timing, counted from the edge that triggers it:
- The first beat is due one cycle after the command is accepted.
- After an accepted non-final beat, the next beat follows after `cfg_gap` cycles with `wvalid` low, that is `cfg_gap+1` cycles after the acceptance.
- After the last beat, `cmd_ready` comes back in the following cycle.

The bench drives on the falling edge and samples on the falling edge just after each rising edge. It counts the low-`wvalid` cycles between beats and compares that count with the gap. It steps its own LFSR and walking-position model only on the edges where it sees a beat accepted, so that stalls and gaps cannot shift the expected data.

// File: rtl/wpat_pkg.sv
package wpat_pkg;

    typedef enum logic [2:0] {
        FILL_CONST = 3'd0,
        FILL_RAND  = 3'd1,
        FILL_SRC   = 3'd2,
        FILL_ADDR  = 3'd3,
        FILL_WALK1 = 3'd4,
        FILL_WALK0 = 3'd5
    } fill_mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_BEAT = 2'd1,
        SEQ_GAP  = 2'd2
    } seq_state_e;

    localparam int          PRNG_W        = 32;
    localparam logic [31:0] PRNG_TAPS     = 32'hA300_0000;
    localparam logic [31:0] PRNG_ALT_SEED = 32'h0000_0001;

    function automatic logic [PRNG_W-1:0] prng_next(input logic [PRNG_W-1:0] s);
        return (s >> 1) ^ (s[0] ? PRNG_TAPS : '0);
    endfunction

    function automatic logic [PRNG_W-1:0] prng_seed(input logic [PRNG_W-1:0] v);
        return (v == '0) ? PRNG_ALT_SEED : v;
    endfunction

endpackage

// File: rtl/wpat_seq.sv
module wpat_seq
    import wpat_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int LEN_W  = 8,
    parameter int SIZE_W = 3,
    parameter int GAP_W  = 8,
    parameter int VAL_W  = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic [SIZE_W-1:0] cmd_size,
    input  logic [2:0]        cmd_mode,
    input  logic [VAL_W-1:0]  cmd_value,
    input  logic [GAP_W-1:0]  cmd_gap,
    input  logic              wready,
    output logic              wvalid,
    output logic              wlast,
    output logic              beat_fire,
    output logic [ADDR_W-1:0] beat_addr,
    output fill_mode_e        cur_mode,
    output logic [VAL_W-1:0]  cur_value,
    output logic [GAP_W-1:0]  cur_gap
);

    seq_state_e        state_q;
    logic [LEN_W-1:0]  beat_q;
    logic [LEN_W-1:0]  len_q;
    logic [SIZE_W-1:0] size_q;
    logic [GAP_W-1:0]  gap_q;
    logic [GAP_W-1:0]  gap_cnt_q;
    logic [ADDR_W-1:0] addr_q;
    fill_mode_e        mode_q;
    logic [VAL_W-1:0]  value_q;
    logic [ADDR_W-1:0] step;

    assign cmd_ready = (state_q == SEQ_IDLE);
    assign wvalid    = (state_q == SEQ_BEAT);
    assign wlast     = wvalid && (beat_q == len_q);
    assign beat_fire = wvalid && wready;
    assign beat_addr = addr_q;
    assign cur_mode  = mode_q;
    assign cur_value = value_q;
    assign cur_gap   = gap_q;
    assign step      = ADDR_W'(1) << size_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= SEQ_IDLE;
            beat_q    <= '0;
            len_q     <= '0;
            size_q    <= '0;
            gap_q     <= '0;
            gap_cnt_q <= '0;
            addr_q    <= '0;
            mode_q    <= FILL_CONST;
            value_q   <= '0;
        end else begin
            case (state_q)
                SEQ_IDLE: begin
                    if (cmd_valid) begin
                        beat_q  <= '0;
                        len_q   <= cmd_len;
                        size_q  <= cmd_size;
                        gap_q   <= cmd_gap;
                        addr_q  <= cmd_addr;
                        mode_q  <= fill_mode_e'(cmd_mode);
                        value_q <= cmd_value;
                        state_q <= SEQ_BEAT;
                    end
                end
                SEQ_BEAT: begin
                    if (wready) begin
                        if (beat_q == len_q) begin
                            state_q <= SEQ_IDLE;
                        end else begin
                            beat_q <= beat_q + 1'b1;
                            addr_q <= addr_q + step;
                            if (gap_q != '0) begin
                                gap_cnt_q <= gap_q - 1'b1;
                                state_q   <= SEQ_GAP;
                            end
                        end
                    end
                end
                SEQ_GAP: begin
                    if (gap_cnt_q == '0) state_q <= SEQ_BEAT;
                    else                 gap_cnt_q <= gap_cnt_q - 1'b1;
                end
                default: state_q <= SEQ_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/wpat_fill.sv
module wpat_fill
    import wpat_pkg::*;
#(
    parameter int          DATA_W = 64,
    parameter int          ADDR_W = 32,
    parameter logic [31:0] SRC_ID = 32'h0000_005A
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [DATA_W-1:0] seed_src,
    input  logic              beat_fire,
    input  fill_mode_e        mode,
    input  logic [DATA_W-1:0] value,
    input  logic [ADDR_W-1:0] beat_addr,
    output logic [DATA_W-1:0] wdata
);

    localparam int POS_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int REP   = (DATA_W + PRNG_W - 1) / PRNG_W;

    logic [PRNG_W-1:0] lfsr_q;
    logic [POS_W-1:0]  pos_q;
    logic [DATA_W-1:0] rnd_word;
    logic [DATA_W-1:0] walk_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            lfsr_q <= prng_seed(PRNG_W'(seed_src));
            pos_q  <= '0;
        end else if (beat_fire) begin
            lfsr_q <= prng_next(lfsr_q);
            pos_q  <= (pos_q == POS_W'(DATA_W - 1)) ? '0 : pos_q + 1'b1;
        end
    end

    generate
        if (DATA_W <= PRNG_W) begin : g_narrow
            assign rnd_word = lfsr_q[DATA_W-1:0];
        end else begin : g_wide
            logic [REP*PRNG_W-1:0] rep_word;
            assign rep_word = {REP{lfsr_q}};
            assign rnd_word = rep_word[DATA_W-1:0];
        end
    endgenerate

    assign walk_mask = DATA_W'(1) << pos_q;

    always_comb begin
        case (mode)
            FILL_RAND:  wdata = rnd_word;
            FILL_SRC:   wdata = DATA_W'(SRC_ID);
            FILL_ADDR:  wdata = DATA_W'(beat_addr);
            FILL_WALK1: wdata = walk_mask;
            FILL_WALK0: wdata = ~walk_mask;
            default:    wdata = value;
        endcase
    end

endmodule

// File: rtl/wpat_gen.sv
module wpat_gen
    import wpat_pkg::*;
#(
    parameter int          DATA_W = 64,
    parameter int          ADDR_W = 32,
    parameter int          LEN_W  = 8,
    parameter int          SIZE_W = 3,
    parameter int          GAP_W  = 8,
    parameter logic [31:0] SRC_ID = 32'h0000_005A
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    output logic                cmd_ready,
    input  logic [ADDR_W-1:0]   cmd_addr,
    input  logic [LEN_W-1:0]    cmd_len,
    input  logic [SIZE_W-1:0]   cmd_size,
    input  logic [2:0]          cfg_mode,
    input  logic [DATA_W-1:0]   cfg_value,
    input  logic [GAP_W-1:0]    cfg_gap,
    output logic                wvalid,
    input  logic                wready,
    output logic [DATA_W-1:0]   wdata,
    output logic [DATA_W/8-1:0] wstrb,
    output logic                wlast
);

    logic              beat_fire;
    logic [ADDR_W-1:0] beat_addr;
    fill_mode_e        act_mode;
    logic [DATA_W-1:0] act_value;
    logic [GAP_W-1:0]  act_gap;

    wpat_seq #(
        .ADDR_W(ADDR_W), .LEN_W(LEN_W), .SIZE_W(SIZE_W),
        .GAP_W(GAP_W), .VAL_W(DATA_W)
    ) u_seq (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_ready (cmd_ready),
        .cmd_addr  (cmd_addr),
        .cmd_len   (cmd_len),
        .cmd_size  (cmd_size),
        .cmd_mode  (cfg_mode),
        .cmd_value (cfg_value),
        .cmd_gap   (cfg_gap),
        .wready    (wready),
        .wvalid    (wvalid),
        .wlast     (wlast),
        .beat_fire (beat_fire),
        .beat_addr (beat_addr),
        .cur_mode  (act_mode),
        .cur_value (act_value),
        .cur_gap   (act_gap)
    );

    wpat_fill #(
        .DATA_W(DATA_W), .ADDR_W(ADDR_W), .SRC_ID(SRC_ID)
    ) u_fill (
        .clk       (clk),
        .rst       (rst),
        .seed_src  (cfg_value),
        .beat_fire (beat_fire),
        .mode      (act_mode),
        .value     (act_value),
        .beat_addr (beat_addr),
        .wdata     (wdata)
    );

    assign wstrb = '1;

endmodule

// File: rtl/wpat_chk.sv
module wpat_chk
    import wpat_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int GAP_W  = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_valid,
    input logic              cmd_ready,
    input logic              wvalid,
    input logic              wready,
    input logic [DATA_W-1:0] wdata,
    input logic              wlast,
    input fill_mode_e        act_mode,
    input logic [GAP_W-1:0]  act_gap
);

    assert_busy_excl_R2: assert property (@(posedge clk) disable iff (rst)
        !(cmd_ready && wvalid));

    assert_first_beat_R2: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_ready) |=> wvalid);

    assert_release_R2: assert property (@(posedge clk) disable iff (rst)
        (wvalid && wready && wlast) |=> (!wvalid && cmd_ready));

    assert_stall_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (wvalid && !wready) |=> (wvalid && $stable(wdata) && $stable(wlast)));

    assert_gap_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (wvalid && wready && !wlast && act_gap != '0) |=> !wvalid);

    assert_no_gap_R9: assert property (@(posedge clk) disable iff (rst)
        (wvalid && wready && !wlast && act_gap == '0) |=> wvalid);

    assert_walk_one_R7: assert property (@(posedge clk) disable iff (rst)
        (wvalid && act_mode == FILL_WALK1) |-> ($countones(wdata) == 1));

    assert_walk_zero_R8: assert property (@(posedge clk) disable iff (rst)
        (wvalid && act_mode == FILL_WALK0) |-> ($countones(~wdata) == 1));

endmodule

bind wpat_gen wpat_chk #(.DATA_W(DATA_W), .GAP_W(GAP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .wvalid    (wvalid),
    .wready    (wready),
    .wdata     (wdata),
    .wlast     (wlast),
    .act_mode  (act_mode),
    .act_gap   (act_gap)
);

// File: tb/wpat_gen_test.sv
module wpat_gen_test;

    localparam logic [31:0] SRC = 32'h0000_005A;

    typedef struct packed {
        logic [2:0]  mode;
        logic [63:0] val;
        logic [31:0] addr;
        logic [7:0]  len;
        logic [2:0]  size;
        logic [7:0]  gap;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 64'hCAFE_F00D_0123_4567, 32'h0000_0100, 8'd3,  3'd3, 8'd0},
        '{3'd1, 64'h0,                   32'h0,         8'd4,  3'd3, 8'd2},
        '{3'd2, 64'h0,                   32'h0000_0040, 8'd1,  3'd2, 8'd1},
        '{3'd3, 64'h0,                   32'h0000_1000, 8'd3,  3'd6, 8'd0},
        '{3'd4, 64'h0,                   32'h0,         8'd7,  3'd3, 8'd0},
        '{3'd5, 64'h0,                   32'h0,         8'd2,  3'd3, 8'd3},
        '{3'd7, 64'h1111_2222_3333_4444, 32'h0,         8'd1,  3'd0, 8'd0},
        '{3'd3, 64'h0,                   32'hFFFF_FFF8, 8'd2,  3'd3, 8'd1},
        '{3'd4, 64'h0,                   32'h0,         8'd70, 3'd3, 8'd0},
        '{3'd6, 64'h0BAD_BEEF_0000_7777, 32'h0,         8'd0,  3'd3, 8'd0}
    };

    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic        cmd_ready;
    logic [31:0] cmd_addr;
    logic [7:0]  cmd_len;
    logic [2:0]  cmd_size;
    logic [2:0]  cfg_mode;
    logic [63:0] cfg_value;
    logic [7:0]  cfg_gap;
    logic        wvalid;
    logic        wready;
    logic [63:0] wdata;
    logic [7:0]  wstrb;
    logic        wlast;

    int checks = 0;
    int fails  = 0;
    logic [31:0] m_lfsr;
    int          m_pos;

    always #5 clk = ~clk;

    wpat_gen #(.SRC_ID(SRC)) uut (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_addr(cmd_addr), .cmd_len(cmd_len), .cmd_size(cmd_size),
        .cfg_mode(cfg_mode), .cfg_value(cfg_value), .cfg_gap(cfg_gap),
        .wvalid(wvalid), .wready(wready), .wdata(wdata), .wstrb(wstrb),
        .wlast(wlast)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] lfsr_step(input logic [31:0] s);
        logic [31:0] n;
        n = {1'b0, s[31:1]};
        if (s[0]) n = n ^ 32'hA300_0000;
        return n;
    endfunction

    function automatic string mode_tag(input logic [2:0] m);
        case (m)
            3'd0: return "R3";
            3'd1: return "R4";
            3'd2: return "R5";
            3'd3: return "R6";
            3'd4: return "R7";
            3'd5: return "R8";
            default: return "R12";
        endcase
    endfunction

    function automatic logic [63:0] expect_data(input vec_t v, input int k);
        logic [31:0] a;
        a = v.addr + (32'(k) << v.size);
        case (v.mode)
            3'd1: return {m_lfsr, m_lfsr};
            3'd2: return 64'(SRC);
            3'd3: return 64'(a);
            3'd4: return 64'd1 << m_pos;
            3'd5: return ~(64'd1 << m_pos);
            default: return v.val;
        endcase
    endfunction

    task automatic do_reset(input logic [63:0] seed);
        rst       = 1'b1;
        cfg_value = seed;
        repeat (2) @(negedge clk);
        check("R1 ready in reset", 64'(cmd_ready), 64'd1);
        check("R1 valid in reset", 64'(wvalid), 64'd0);
        rst = 1'b0;
        m_lfsr = (seed[31:0] == 32'd0) ? 32'd1 : seed[31:0];
        m_pos  = 0;
        @(negedge clk);
        check("R1 ready after reset", 64'(cmd_ready), 64'd1);
        check("R1 valid after reset", 64'(wvalid), 64'd0);
    endtask

    // Starts at a negedge with the block idle; ends at the negedge after the last beat.
    task automatic run_burst(input vec_t v, input int stall);
        int          idle;
        logic [63:0] held;
        check("R2 idle before command", 64'(cmd_ready), 64'd1);
        cmd_valid = 1'b1;
        cmd_addr  = v.addr;
        cmd_len   = v.len;
        cmd_size  = v.size;
        cfg_mode  = v.mode;
        cfg_value = v.val;
        cfg_gap   = v.gap;
        wready    = (stall == 0);
        @(negedge clk);
        cmd_valid = 1'b0;
        cfg_value = ~v.val;
        cfg_gap   = ~v.gap;
        cfg_mode  = ~v.mode;
        for (int k = 0; k <= int'(v.len); k++) begin
            idle = 0;
            while (!wvalid && idle < 300) begin
                idle++;
                @(negedge clk);
            end
            check("R9 idle cycles before beat", 64'(idle), (k == 0) ? 64'd0 : 64'(v.gap));
            check("R2 ready low in burst", 64'(cmd_ready), 64'd0);
            check({mode_tag(v.mode), " beat data"}, wdata, expect_data(v, k));
            check("R2 wlast position", 64'(wlast), 64'(k == int'(v.len)));
            check("R11 strobes", 64'(wstrb), 64'hFF);
            if (k == 0 && stall > 0) begin
                held = wdata;
                for (int s = 0; s < stall; s++) begin
                    @(negedge clk);
                    check("R10 valid held in stall", 64'(wvalid), 64'd1);
                    check("R10 data held in stall", wdata, held);
                    check("R10 wlast held in stall", 64'(wlast), 64'(v.len == 8'd0));
                end
                wready = 1'b1;
            end
            @(negedge clk);
            m_lfsr = lfsr_step(m_lfsr);
            m_pos  = (m_pos == 63) ? 0 : m_pos + 1;
        end
        check("R2 valid low after last", 64'(wvalid), 64'd0);
        check("R2 ready after last", 64'(cmd_ready), 64'd1);
    endtask

    initial begin
        rst       = 1'b1;
        cmd_valid = 1'b0;
        cmd_addr  = '0;
        cmd_len   = '0;
        cmd_size  = '0;
        cfg_mode  = '0;
        cfg_value = '0;
        cfg_gap   = '0;
        wready    = 1'b1;
        @(negedge clk);
        do_reset(64'hDEAD_BEEF_1234_ABCD);

        for (int i = 0; i < NV; i++) run_burst(VECS[i], 0);

        // R10: stall on first beat, walking one, back-to-back beats
        run_burst('{3'd4, 64'h0, 32'h0, 8'd2, 3'd3, 8'd0}, 3);
        // R10: stall on a single-beat random burst
        run_burst('{3'd1, 64'h0, 32'h0, 8'd0, 3'd3, 8'd0}, 2);

        // R4: zero seed replaced by 1; R7 position restarts at reset
        do_reset(64'h0);
        cmd_valid = 1'b1; cmd_addr = '0; cmd_len = 8'd0; cmd_size = 3'd3;
        cfg_mode = 3'd1; cfg_gap = '0;
        @(negedge clk);
        cmd_valid = 1'b0;
        check("R4 zero seed substitution", wdata, 64'h0000_0001_0000_0001);
        @(negedge clk);
        m_lfsr = lfsr_step(m_lfsr);
        m_pos  = 1;
        run_burst('{3'd4, 64'h0, 32'h0, 8'd1, 3'd3, 8'd1}, 0);
        run_burst('{3'd1, 64'h0, 32'h0, 8'd1, 3'd3, 8'd0}, 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule